// File: doc/BRIEF.md
# Delayed Power-Good Generator

This block produces a single power-good flag for a supply controller. Three conditioning flags come in from analog comparators: the external power-good sense above its upper threshold, the 3.3 V rail above its under-voltage level and the 5 V rail above its under-voltage level. The flag rises only after all three have been good without a break for a long qualification window. It falls after a short deglitch window once any of them is lost. A latched over-voltage or under-voltage fault from the fault controller, or an inactive on/off request, pulls the flag low at the next clock edge.

Both windows are counted in pulses of a `tick` input, so one clock domain can serve any time base. With a 1 µs tick, the defaults of 300000 and 150 ticks give 300 ms and 150 µs. A high output means every rail is good. A low output means a fault or a not-ready supply. The block has no data stream, so every pin is a plain level or pulse and there is no handshake.

Top module: `pg_delay_gen`

## Requirements
- R1: While `rst_n` is low, and in the cycle after it is released, `pwr_good` is 0.
- R2: `pwr_good` goes to 1 once `sense_ok`, `rail33_ok` and `rail5_ok` have all been 1 through QUAL_TICKS `tick` pulses in a row, with no block active. After QUAL_TICKS-1 such pulses it is still 0.
- R3: If any good flag drops during qualification, even for one cycle, the qualification count starts again from zero.
- R4: While `pwr_good` is 1, a loss of any good flag that lasts through DROP_TICKS `tick` pulses drives `pwr_good` to 0. After DROP_TICKS-1 pulses it is still 1.
- R5: A loss shorter than DROP_TICKS pulses leaves `pwr_good` at 1, and the deglitch count starts again from zero on the next loss.
- R6: Each of the three good flags, on its own, both prevents qualification and triggers the deglitched drop.
- R7: `fault_latched` = 1 drives `pwr_good` to 0 at the next clock edge. Once it clears, a full QUAL_TICKS qualification is needed again.
- R8: `on_req` = 0 (supply requested off) drives `pwr_good` to 0 at the next clock edge and holds qualification at zero.
- R9: Clock cycles without a `tick` pulse do not advance either window. Both counts saturate at their limits and never wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle time-base pulse |
| sense_ok | input | 1 | External power-good sense above its upper threshold |
| rail33_ok | input | 1 | 3.3 V rail above its under-voltage level |
| rail5_ok | input | 1 | 5 V rail above its under-voltage level |
| fault_latched | input | 1 | Latched fault from the fault controller, 1 = fault |
| on_req | input | 1 | On/off request, 1 = supply requested on |
| pwr_good | output | 1 | Delayed power-good, 1 = all rails good |

## Verification
The hardest cases to reach are the two exact boundaries under restarts. One is a glitch that lands one tick before qualification ends. The other is a short loss, followed by a second loss, whose count must start again from zero. The bench drives `tick` itself, one pulse at a time, so it knows the exact tick count at every point. It checks the output one tick before and one tick after each limit, after a one-cycle dropout placed QUAL_TICKS-1 ticks into a qualification, and after a loss of DROP_TICKS-1 ticks followed by another loss of DROP_TICKS-1 ticks.

// File: rtl/pg_pkg.sv
package pg_pkg;
  localparam int NUM_COND = 3;
  typedef logic [NUM_COND-1:0] cond_vec_t;
endpackage

// File: rtl/pg_sat_counter.sv
module pg_sat_counter #(
  parameter int LIMIT = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic cnt_done
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) cnt <= '0;
    else if (inc && cnt != LIM) cnt <= cnt + 1'b1;
  end

  assign cnt_done = (cnt == LIM);

  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LIM); // R9
  AST_CNT_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !inc) |=> $stable(cnt)); // R9
endmodule

// File: rtl/pg_out_ctrl.sv
module pg_out_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic block,
  input  logic qual_done,
  input  logic drop_done,
  output logic pwr_good
);
  always_ff @(posedge clk) begin
    if (!rst_n || block)            pwr_good <= 1'b0;
    else if (!pwr_good && qual_done) pwr_good <= 1'b1;
    else if (pwr_good && drop_done)  pwr_good <= 1'b0;
  end

  AST_BLOCK_FORCES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    block |=> !pwr_good); // R7
  AST_RISE_NEEDS_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(qual_done)); // R2
  AST_HOLD_WITHOUT_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_good && !block && !drop_done) |=> pwr_good); // R5
endmodule

// File: rtl/pg_delay_gen.sv
module pg_delay_gen #(
  parameter int QUAL_TICKS = 300000,
  parameter int DROP_TICKS = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic sense_ok,
  input  logic rail33_ok,
  input  logic rail5_ok,
  input  logic fault_latched,
  input  logic on_req,
  output logic pwr_good
);
  import pg_pkg::*;

  cond_vec_t conds;
  logic all_ok, block, qual_done, drop_done;

  assign conds  = {sense_ok, rail33_ok, rail5_ok};
  assign all_ok = &conds;
  assign block  = fault_latched || !on_req;

  pg_sat_counter #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk(clk), .rst_n(rst_n),
    .clr(block || !all_ok),
    .inc(tick),
    .cnt_done(qual_done)
  );

  pg_sat_counter #(.LIMIT(DROP_TICKS)) u_drop (
    .clk(clk), .rst_n(rst_n),
    .clr(block || all_ok || !pwr_good),
    .inc(tick),
    .cnt_done(drop_done)
  );

  pg_out_ctrl u_out (
    .clk(clk), .rst_n(rst_n),
    .block(block),
    .qual_done(qual_done),
    .drop_done(drop_done),
    .pwr_good(pwr_good)
  );

  AST_RESET_LOW: assert property (@(posedge clk)
    !rst_n |=> !pwr_good); // R1
  AST_OFF_REQ_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !on_req |=> !pwr_good); // R8
  AST_RISE_ALL_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(all_ok)); // R6
  AST_FALL_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |-> ($past(block) || $past(drop_done))); // R4
endmodule

// File: tb/test_pg_delay_gen.sv
module test_pg_delay_gen;
  localparam int Q = 20;
  localparam int D = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic sense_ok = 1'b0, rail33_ok = 1'b0, rail5_ok = 1'b0;
  logic fault_latched = 1'b0, on_req = 1'b0;
  logic pwr_good;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic  exp;
    string tag;
  } exp_item_t;
  exp_item_t sb[$];

  always #2 clk = ~clk;

  pg_delay_gen #(.QUAL_TICKS(Q), .DROP_TICKS(D)) i_pg_delay_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .sense_ok(sense_ok), .rail33_ok(rail33_ok), .rail5_ok(rail5_ok),
    .fault_latched(fault_latched), .on_req(on_req), .pwr_good(pwr_good)
  );

  // monitor: pops one expectation per falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (sb.size() > 0) begin
        exp_item_t it;
        it = sb.pop_front();
        checks++;
        if (pwr_good !== it.exp) begin
          fails++;
          $display("FAIL %s: pwr_good=%b expected=%b", it.tag, pwr_good, it.exp);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: run did not complete, expected end before 100000 cycles");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
      end
    end
  end

  task automatic step(int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic ticks(int n);
    repeat (n) begin
      tick = 1'b1; step(1);
      tick = 1'b0; step(1);
    end
  endtask

  task automatic expect_pg(logic e, string tag);
    exp_item_t it;
    it.exp = e;
    it.tag = tag;
    sb.push_back(it);
    wait (sb.size() == 0);
    step(1);
  endtask

  task automatic all_good(logic v);
    sense_ok = v; rail33_ok = v; rail5_ok = v;
  endtask

  // bring output high from a clean low state
  task automatic qualify();
    all_good(1'b1); step(1);
    ticks(Q);
  endtask

  initial begin
    step(2);
    expect_pg(1'b0, "R1 in reset");
    rst_n = 1'b1;
    expect_pg(1'b0, "R1 after reset release");

    // R8: all good but supply requested off
    all_good(1'b1);
    ticks(Q + 3);
    expect_pg(1'b0, "R8 on_req low blocks");

    // R9: no ticks, no progress
    on_req = 1'b1;
    step(200);
    expect_pg(1'b0, "R9 no tick no advance");

    // R2 boundary
    ticks(Q - 1);
    expect_pg(1'b0, "R2 one tick short");
    ticks(1);
    expect_pg(1'b1, "R2 asserted after full window");
    ticks(Q * 3);
    expect_pg(1'b1, "R9 stays high, no wrap");

    // R4 boundary, via rail33
    rail33_ok = 1'b0; step(1);
    ticks(D - 1);
    expect_pg(1'b1, "R4 one tick short of drop");
    ticks(1);
    expect_pg(1'b0, "R4 dropped after deglitch");
    ticks(D * 4);
    expect_pg(1'b0, "R9 long loss stays low");

    // R3: glitch restarts qualification
    all_good(1'b1); step(1);
    ticks(Q - 1);
    rail5_ok = 1'b0; step(1);
    rail5_ok = 1'b1; step(1);
    ticks(Q - 1);
    expect_pg(1'b0, "R3 restart after glitch");
    ticks(1);
    expect_pg(1'b1, "R3 high after fresh window");

    // R5: short loss then another short loss
    sense_ok = 1'b0; step(1);
    ticks(D - 1);
    sense_ok = 1'b1; step(1);
    expect_pg(1'b1, "R5 short loss ignored");
    sense_ok = 1'b0; step(1);
    ticks(D - 1);
    expect_pg(1'b1, "R5 deglitch count restarted");
    ticks(1);
    expect_pg(1'b0, "R6 sense_ok alone drops");

    // R6: each flag alone blocks qualification
    sense_ok = 1'b1; rail33_ok = 1'b1; rail5_ok = 1'b0; step(1);
    ticks(Q + 2);
    expect_pg(1'b0, "R6 rail5_ok alone blocks");
    rail5_ok = 1'b1; rail33_ok = 1'b0; step(1);
    ticks(Q + 2);
    expect_pg(1'b0, "R6 rail33_ok alone blocks");
    rail33_ok = 1'b1; sense_ok = 1'b0; step(1);
    ticks(Q + 2);
    expect_pg(1'b0, "R6 sense_ok alone blocks");
    sense_ok = 1'b1; step(1);
    ticks(Q);
    expect_pg(1'b1, "R6 all three restore");

    // R6: rail5 alone drops
    rail5_ok = 1'b0; step(1);
    ticks(D);
    expect_pg(1'b0, "R6 rail5_ok alone drops");

    // R7: fault immediate, then full requalification
    qualify();
    expect_pg(1'b1, "R7 setup high");
    fault_latched = 1'b1; step(1);
    expect_pg(1'b0, "R7 fault forces low next edge");
    fault_latched = 1'b0; step(1);
    ticks(Q - 1);
    expect_pg(1'b0, "R7 requalify one tick short");
    ticks(1);
    expect_pg(1'b1, "R7 requalified");

    // R8: on_req low while high
    on_req = 1'b0; step(1);
    expect_pg(1'b0, "R8 off request forces low");
    on_req = 1'b1; step(1);
    ticks(Q);
    expect_pg(1'b1, "R8 back on after full window");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule